// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing sequencer of a small serial EEPROM. It samples the two-wire clock and data lines with the system clock. On those samples it finds START and STOP conditions. After a START it matches the device address byte and the direction bit. It then loads a word pointer, and it either passes received data bytes to a page write buffer or shifts stored bytes out to the master. SDA is driven open-drain: `sda_oe_o` high pulls the line low. The block never drives it high.

Write bytes leave the block on a valid/ready stream. A captured byte raises `wr_valid_o` with `wr_addr_o` and `wr_data_o`. Valid, address and data stay unchanged until `wr_ready_i` is high on a clock edge. The only other way valid drops is that the ninth SCL clock begins first. In that case the byte is refused and the block declines it on the bus. The storage side may stall for up to the rest of the eighth SCL high phase. A STOP that closes a write holding at least one accepted byte pulses `wr_commit_o` for one clock. That pulse is the trigger for the programming cycle. Reads use a plain combinational port: the storage returns `rd_data_i` for the current `rd_addr_o`. While `busy_i` reports a programming cycle, START conditions are not taken, so the block stays silent on the bus.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, and until a START (SDA falling while SCL is high) has been seen, the block never pulls SDA low, whatever bytes are clocked on the bus.
- R2: After a START, the first byte is taken MSB first as a 7-bit device address followed by a direction bit (0 = write, 1 = read). Only device address 7'h50, that is bytes 8'hA0 and 8'hA1, is acknowledged by pulling SDA low through the ninth SCL clock. Any other address gets no acknowledge, and all later bytes are ignored until the next START.
- R3: In a write, the second byte is acknowledged and loads the 7-bit word pointer from its low 7 bits. Each later byte is acknowledged and presented on the write stream with the pointer value. The pointer then steps by one, wrapping from 127 to 0.
- R4: A STOP (SDA rising while SCL is high) returns the block to idle. If the ending write had at least one accepted data byte, `wr_commit_o` pulses once. A write that ends after only the word address does not pulse it.
- R5: While `busy_i` is high, a START and a matching address get no acknowledge.
- R6: In a read, each byte is driven MSB first from `rd_data_i` at `rd_addr_o`, starting from the current pointer. SDA changes only in the SCL low phase. After each byte the pointer steps by one, wrapping from 127 to 0, and a master acknowledge (SDA low on the ninth clock) starts the next byte.
- R7: A missing master acknowledge after a read byte releases SDA. The block then ignores the bus until STOP, and answers again after that STOP.
- R8: A repeated START in the middle of a transfer restarts the address phase. The pointer is kept, so a write of the word address followed by a repeated START with a read returns data from that address.
- R9: Write-stream back-pressure: valid, address and data are held until ready is seen. A byte accepted late within the eighth SCL high phase is still acknowledged. A byte not accepted before the ninth clock begins is refused with no acknowledge and never handed over, and the block then waits for STOP.
- R10: The SDA drive enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| busy_i | input | 1 | Storage is in its programming cycle |
| wr_valid_o | output | 1 | Write byte available |
| wr_ready_i | input | 1 | Page buffer takes the write byte |
| wr_addr_o | output | 7 | Word address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | One-clock pulse at STOP ending a write with data |
| rd_addr_o | output | 7 | Word address for the read port |
| rd_data_i | input | 8 | Stored byte at rd_addr_o |

## Verification
The bench sweeps all 128 device addresses in both directions. An address comparator that checks too few bits, or none, acknowledges a neighbour of 7'h50 and is caught there. Reads and writes that cross word address 127 catch a pointer that saturates or does not step. A read ended by a missing acknowledge is followed by a byte that looks like a valid address, which exposes a block that keeps driving or re-arms without a STOP. Refused and late-accepted write bytes catch an acknowledge decided before the handshake window closes, or valid data that changes while stalled. A design that drops the pointer on a repeated START returns the wrong read data.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WADDR,
    S_WADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK,
    S_RNEXT,
    S_WSTOP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] lvl_q_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl_o[g]   = chain[STAGES-1];
    assign lvl_q_o[g] = last;
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl_i,
  input  logic scl_q_i,
  input  logic sda_i,
  input  logic sda_q_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  always_comb begin
    scl_rise_o = scl_i & ~scl_q_i;
    scl_fall_o = ~scl_i & scl_q_i;
    start_o    = scl_i & scl_q_i & sda_q_i & ~sda_i;
    stop_o     = scl_i & scl_q_i & ~sda_q_i & sda_i;
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter int               AW       = 7,
  parameter int               DW       = 8,
  parameter logic [DW-2:0]    DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          busy_i,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_commit_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  slv_state_e    state;
  logic [DW-1:0] shreg, txbuf;
  logic [DW-1:0] nb;
  logic [CW-1:0] bitcnt;
  logic [AW-1:0] ptr;
  logic          phase, rw_q, acc_q, ackd_q, wrote_q;
  logic          oe, wv, commit;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;

  assign nb = {shreg[DW-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; shreg <= '0; txbuf <= '0; bitcnt <= '0; ptr <= '0;
      phase <= 1'b0; rw_q <= 1'b0; acc_q <= 1'b0; ackd_q <= 1'b0;
      wrote_q <= 1'b0; oe <= 1'b0; wv <= 1'b0; commit <= 1'b0;
      wa <= '0; wd <= '0;
    end else begin
      commit <= 1'b0;
      if (wv && wr_ready_i) begin
        wv      <= 1'b0;
        acc_q   <= 1'b1;
        wrote_q <= 1'b1;
      end
      if (stop_i) begin
        state   <= S_IDLE;
        oe      <= 1'b0;
        wv      <= 1'b0;
        commit  <= wrote_q | (wv & wr_ready_i);
        wrote_q <= 1'b0;
      end else if (start_i && !busy_i) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        phase  <= 1'b0;
        oe     <= 1'b0;
        wv     <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WADDR, S_WDATA: begin
            if (scl_rise_i) begin
              shreg  <= nb;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                bitcnt <= '0;
                phase  <= 1'b0;
                if (state == S_ADDR) begin
                  if (nb[DW-1:1] == DEV_ADDR) begin
                    rw_q  <= nb[0];
                    state <= S_ADDR_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end else if (state == S_WADDR) begin
                  ptr   <= nb[AW-1:0];
                  state <= S_WADDR_ACK;
                end else begin
                  wv    <= 1'b1;
                  wd    <= nb;
                  wa    <= ptr;
                  ptr   <= ptr + 1'b1;
                  acc_q <= 1'b0;
                  state <= S_WDATA_ACK;
                end
              end
            end
          end
          S_ADDR_ACK, S_WADDR_ACK: begin
            if (scl_fall_i) begin
              if (!phase) begin
                phase <= 1'b1;
                oe    <= 1'b1;
              end else begin
                phase <= 1'b0;
                if (state == S_ADDR_ACK && rw_q) begin
                  txbuf <= {rd_data_i[DW-2:0], 1'b0};
                  oe    <= ~rd_data_i[DW-1];
                  state <= S_RDATA;
                end else begin
                  oe    <= 1'b0;
                  state <= (state == S_ADDR_ACK) ? S_WADDR : S_WDATA;
                end
              end
            end
          end
          S_WDATA_ACK: begin
            if (scl_fall_i) begin
              if (!phase) begin
                phase  <= 1'b1;
                oe     <= acc_q | (wv & wr_ready_i);
                ackd_q <= acc_q | (wv & wr_ready_i);
                if (!(wv && wr_ready_i)) wv <= 1'b0;
              end else begin
                phase <= 1'b0;
                oe    <= 1'b0;
                state <= ackd_q ? S_WDATA : S_WSTOP;
              end
            end
          end
          S_RDATA: begin
            if (scl_fall_i) begin
              oe    <= ~txbuf[DW-1];
              txbuf <= {txbuf[DW-2:0], 1'b0};
            end else if (scl_rise_i) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                bitcnt <= '0;
                ptr    <= ptr + 1'b1;
                state  <= S_RACK;
              end
            end
          end
          S_RACK: begin
            if (scl_fall_i) oe <= 1'b0;
            else if (scl_rise_i) state <= sda_i ? S_WSTOP : S_RNEXT;
          end
          S_RNEXT: begin
            if (scl_fall_i) begin
              txbuf <= {rd_data_i[DW-2:0], 1'b0};
              oe    <= ~rd_data_i[DW-1];
              state <= S_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe;
  assign wr_valid_o  = wv;
  assign wr_addr_o   = wa;
  assign wr_data_o   = wd;
  assign wr_commit_o = commit;
  assign rd_addr_o   = ptr;

  // R10: drive enable moves only in the SCL low phase
  p_oe_only_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> !scl_lvl_i);
  // R5: an idle block that sees busy stays off the bus
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && state == S_IDLE) |=> !oe);
  // R4: commit only as a consequence of a STOP
  p_commit_follows_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_i));
  // R9: stalled write byte keeps its payload
  p_valid_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wv && !wr_ready_i && !scl_fall_i && !stop_i && !start_i) |=> (wv && $stable(wd) && $stable(wa)));
  // R8: a START always rearms the address phase
  p_start_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && !busy_i) |=> (state == S_ADDR));
  // R7: nothing is driven while waiting for STOP
  p_nack_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WSTOP) |-> !oe);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int            AW          = 7,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-2:0] DEV_ADDR    = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          busy_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_commit_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  logic [1:0] lvl, lvl_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   ({scl_i, sda_i}),
    .lvl_o   (lvl),
    .lvl_q_o (lvl_q)
  );

  i2c_bus_events u_events (
    .scl_i      (lvl[1]),
    .scl_q_i    (lvl_q[1]),
    .sda_i      (lvl[0]),
    .sda_q_i    (lvl_q[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slave_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl_i   (lvl[1]),
    .sda_i       (lvl[0]),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .busy_i      (busy_i),
    .sda_oe_o    (sda_oe_o),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_commit_o (wr_commit_o),
    .rd_addr_o   (rd_addr_o),
    .rd_data_i   (rd_data_i)
  );
endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic       sda_oe, wr_valid, wr_ready, wr_commit;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       sda_bus;
  logic [7:0] mem [128];
  logic [6:0] wl_a [64];
  logic [7:0] wl_d [64];
  int         wn = 0, ncommit = 0, r10_bad = 0;
  logic       prev_oe = 1'b0;
  logic [3:0] vcnt = '0;
  int         rdy_mode = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = mem[rd_addr];
  assign wr_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : (vcnt >= 4'd3);

  i2c_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .busy_i(busy), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      if (wn < 64) begin
        wl_a[wn] <= wr_addr;
        wl_d[wn] <= wr_data;
      end
      wn <= wn + 1;
    end
    if (wr_commit) ncommit <= ncommit + 1;
    vcnt <= wr_valid ? vcnt + 4'd1 : 4'd0;
  end

  always @(negedge clk) begin
    prev_oe <= sda_oe;
    if (rst_n && sda_oe != prev_oe && scl_m) r10_bad <= r10_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = !sda_bus;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
      d[i] = sda_bus;
      w(Q); scl_m = 1'b0; w(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_byte(int a);
    if (a == 8'h7F) return 8'hC3;
    if (a == 0) return 8'h3C;
    if (a >= 8'h10 && a <= 8'h12) return 8'((a - 8'h0F) * 8'h11);
    if (a == 8'h30) return 8'h5A;
    return init_val(a);
  endfunction

  initial begin
    bit ack;
    logic [7:0] d;
    int c0, w0;
    w(5); rst_n = 1'b1; w(4);
    chk(sda_oe == 0 && wr_valid == 0 && wr_commit == 0, "R1 reset state", int'(sda_oe), 0);

    // R1: bytes with no START are ignored
    scl_m = 1'b0; w(Q);
    send_byte(8'hA0, ack);
    chk(ack == 0, "R1 no ack without START", int'(ack), 0);
    send_byte(8'hA1, ack);
    chk(ack == 0, "R1 no ack without START (read byte)", int'(ack), 0);
    i2c_stop();

    // R2: sweep of every device address in both directions
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        i2c_start();
        send_byte(8'((a << 1) | rw), ack);
        chk(ack == (a == 8'h50), "R2 address sweep", int'(ack), int'(a == 8'h50));
        if (ack && rw == 1) recv_byte(1'b0, d);
        if (!ack) begin
          send_byte(8'hA0, ack);
          chk(ack == 0, "R2 bytes ignored after mismatch", int'(ack), 0);
        end
        i2c_stop();
      end
    end
    chk(ncommit == 0, "R4 no commit without data", ncommit, 0);

    // R3/R4: page of three bytes at 0x10
    w0 = wn; c0 = ncommit;
    i2c_start();
    send_byte(8'hA0, ack); chk(ack, "R3 address ack", int'(ack), 1);
    send_byte(8'h10, ack); chk(ack, "R3 word address ack", int'(ack), 1);
    for (int k = 1; k <= 3; k++) begin
      send_byte(8'(k * 8'h11), ack);
      chk(ack, "R3 data ack", int'(ack), 1);
    end
    i2c_stop(); w(4);
    chk(wn == w0 + 3, "R3 write count", wn, w0 + 3);
    for (int k = 0; k < 3; k++) begin
      chk(wl_a[w0+k] == 7'(8'h10 + k), "R3 write address", int'(wl_a[w0+k]), 8'h10 + k);
      chk(wl_d[w0+k] == 8'((k + 1) * 8'h11), "R3 write data", int'(wl_d[w0+k]), (k + 1) * 8'h11);
    end
    chk(ncommit == c0 + 1, "R4 one commit at STOP", ncommit, c0 + 1);

    // R3: pointer wrap on write
    w0 = wn;
    i2c_start();
    send_byte(8'hA0, ack); send_byte(8'h7F, ack);
    send_byte(8'hC3, ack); send_byte(8'h3C, ack);
    i2c_stop(); w(4);
    chk(wl_a[w0] == 7'h7F && wl_a[w0+1] == 7'h00, "R3 pointer wraps 127 to 0",
        int'(wl_a[w0+1]), 0);

    // R4: word address only, no commit
    c0 = ncommit;
    i2c_start(); send_byte(8'hA0, ack); send_byte(8'h44, ack); i2c_stop(); w(4);
    chk(ncommit == c0, "R4 address-only write has no commit", ncommit, c0);

    // R5: busy blocks the bus
    busy = 1'b1;
    i2c_start(); send_byte(8'hA0, ack);
    chk(ack == 0, "R5 no ack while busy", int'(ack), 0);
    i2c_stop(); busy = 1'b0;
    i2c_start(); send_byte(8'hA0, ack);
    chk(ack == 1, "R5 ack once busy clears", int'(ack), 1);
    i2c_stop();

    // R6/R8: random read across the wrap via repeated START
    i2c_start();
    send_byte(8'hA0, ack); send_byte(8'h7D, ack);
    i2c_start();
    send_byte(8'hA1, ack); chk(ack, "R8 read address ack after repeated START", int'(ack), 1);
    for (int k = 0; k < 5; k++) begin
      recv_byte(k < 4, d);
      chk(d == exp_byte((8'h7D + k) & 127), "R6 R8 read data", int'(d), int'(exp_byte((8'h7D + k) & 127)));
    end
    w(2);
    chk(sda_oe == 0, "R7 SDA released after missing ack", int'(sda_oe), 0);
    send_byte(8'hA0, ack);
    chk(ack == 0, "R7 bus ignored until STOP", int'(ack), 0);
    i2c_stop();
    i2c_start(); send_byte(8'hA1, ack);
    chk(ack == 1, "R7 answers after STOP", int'(ack), 1);
    recv_byte(1'b0, d);
    chk(d == exp_byte(2), "R6 read continues from pointer", int'(d), int'(exp_byte(2)));
    i2c_stop();

    // R9: refused byte
    w0 = wn; c0 = ncommit; rdy_mode = 1;
    i2c_start(); send_byte(8'hA0, ack); send_byte(8'h20, ack);
    send_byte(8'h99, ack);
    chk(ack == 0, "R9 refused byte not acknowledged", int'(ack), 0);
    send_byte(8'h98, ack);
    chk(ack == 0, "R9 waits for STOP after refusal", int'(ack), 0);
    i2c_stop(); w(4);
    chk(wn == w0 && ncommit == c0, "R9 refused byte not handed over", wn, w0);

    // R9: late acceptance still acknowledged
    rdy_mode = 2;
    i2c_start(); send_byte(8'hA0, ack); send_byte(8'h30, ack);
    send_byte(8'h5A, ack);
    chk(ack == 1, "R9 late accept acknowledged", int'(ack), 1);
    i2c_stop(); w(4); rdy_mode = 0;
    chk(wn == w0 + 1 && wl_a[w0] == 7'h30 && wl_d[w0] == 8'h5A, "R9 late accepted byte",
        int'(wl_d[w0]), 8'h5A);
    chk(ncommit == c0 + 1, "R4 commit after late accept", ncommit, c0 + 1);

    chk(r10_bad == 0, "R10 SDA drive changes only with SCL low", r10_bad, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule